// File: doc/BRIEF.md
# Gated Oscillator-Count Temperature Readout

This block converts the frequency of a free-running, temperature-dependent oscillator into a calibrated digital temperature. A gate input opens a counting window. While the window is open, a 10-bit counter clocked by the oscillator counts its rising edges. When the gate falls, the final count is frozen in a holding register and the counter goes back to zero. The oscillator enable output follows the gate, so the oscillator runs only while a window is open.

The frozen count crosses into the system clock domain through a toggle handshake. A sequencer in the system domain then applies a linear calibration with a negative slope, in Q8.8 fixed point: `temp = 101197 - 132 * count`, clamped to the range 0 to 25600 (0 °C to 100 °C in steps of 1/256 °C). It presents the count, the overflow flag and the temperature together with a one-cycle valid pulse. A hotter die gives a slower oscillator, a smaller count and therefore a higher reading.

There are two state machines. The oscillator-domain machine has the states IDLE and RUN. IDLE→RUN is taken when the synchronised gate is seen high, and the first edge is counted on that transition. RUN→RUN is taken while the gate stays high, counting or saturating. RUN→IDLE is taken when the gate is seen low: the count is captured, the handshake toggles and the counter clears. The system-domain machine has the states WAIT and PUBLISH. WAIT→PUBLISH is taken when a handshake toggle is detected, and the transferred count is latched on that transition. PUBLISH→WAIT is always taken after one cycle, during which the outputs update and the valid pulse is high.

Top module: `temp_readout`

## Requirements
- R1: If the gate is high for exactly N whole oscillator periods, with gate changes aligned between oscillator rising edges, and N ≤ 1023, the reported count is N.
- R2: The counter saturates at 1023 instead of wrapping. `overflow` is 1 for a window in which a further edge arrived after 1023 was reached (N ≥ 1024), and 0 otherwise (N = 1023 reports 1023 with overflow 0).
- R3: Each window starts counting from zero, so the result of a window does not depend on earlier windows.
- R4: `osc_en` is low whenever `gate` is low, and high whenever `gate` is high.
- R5: `held_count`, `overflow` and `temp_q` change only in a cycle in which `result_valid` is high.
- R6: `temp_q` is the unsigned 16-bit Q8.8 value max(0, min(25600, 101197 − 132 × count)), where count is the reported count.
- R7: The clamp limits apply exactly at their edges: counts ≤ 572 give 25600, count 573 gives 25561, count 766 gives 85, and counts ≥ 767 give 0.
- R8: Each completed window produces exactly one `result_valid` pulse, one system cycle long, and the outputs carry that window's result in the same cycle.
- R9: A synchronous `rst` clears `held_count`, `overflow`, `temp_q` and `result_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| osc_clk | input | 1 | Oscillator output that is counted |
| gate | input | 1 | Window control; high opens the counting window |
| osc_en | output | 1 | Oscillator enable; follows gate |
| held_count | output | 10 | Count of the last completed window |
| overflow | output | 1 | Saturation flag of the last completed window |
| temp_q | output | 16 | Calibrated temperature, Q8.8, in the range 0 to 25600 |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The windows are driven with lengths chosen to separate distinct faults. Short windows (1 and 5 periods) expose off-by-one errors at the start and at the capture. Counts 572/573 and 766/767 sit on either side of both clamp limits and check the slope and offset arithmetic exactly. Windows of 1023, 1024 and 1100 periods tell saturation apart from wrap-around and from a missing overflow flag. Back-to-back windows of different lengths, run at two oscillator periods, show that the counter restarts every window. A reset between windows shows the outputs cleared and the next result still correct.

// File: rtl/temp_readout_pkg.sv
`timescale 1ns/1ps
package temp_readout_pkg;
    localparam int DEF_CNT_W  = 10;
    localparam int DEF_TEMP_W = 16;
    localparam int DEF_SLOPE  = 132;
    localparam int DEF_OFFSET = 101197;
    localparam int DEF_TMAX   = 25600;

    typedef enum logic { C_IDLE, C_RUN } cnt_state_e;
    typedef enum logic { S_WAIT, S_PUBLISH } seq_state_e;
endpackage

// File: rtl/bit_sync2.sv
`timescale 1ns/1ps
module bit_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/osc_window_counter.sv
`timescale 1ns/1ps
module osc_window_counter
    import temp_readout_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             osc_clk,
    input  logic             osc_rst,
    input  logic             run_i,
    output logic [CNT_W-1:0] hold_cnt_o,
    output logic             hold_ovf_o,
    output logic             hold_tog_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_comb begin
        unique case (state_q)
            C_IDLE: state_d = run_i ? C_RUN : C_IDLE;
            C_RUN:  state_d = run_i ? C_RUN : C_IDLE;
        endcase
    end

    always_ff @(posedge osc_clk) begin
        if (osc_rst) state_q <= C_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            cnt_q      <= '0;
            ovf_q      <= 1'b0;
            hold_cnt_o <= '0;
            hold_ovf_o <= 1'b0;
            hold_tog_o <= 1'b0;
        end else begin
            unique case (state_q)
                C_IDLE: begin
                    ovf_q <= 1'b0;
                    cnt_q <= run_i ? CNT_W'(1) : '0;
                end
                C_RUN: begin
                    if (run_i) begin
                        if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
                        else                  cnt_q <= cnt_q + 1'b1;
                    end else begin
                        hold_cnt_o <= cnt_q;
                        hold_ovf_o <= ovf_q;
                        hold_tog_o <= ~hold_tog_o;
                        cnt_q      <= '0;
                        ovf_q      <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R1: every edge inside the window advances the count by one below the limit
    assert_count_step_R1: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (state_q == C_RUN && run_i && cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

    // R2: once at the limit the count stays there and the flag is raised
    assert_no_wrap_R2: assert property (@(posedge osc_clk) disable iff (osc_rst)
        (state_q == C_RUN && run_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && ovf_q));
endmodule

// File: rtl/temp_calib.sv
`timescale 1ns/1ps
module temp_calib
    import temp_readout_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int TEMP_W = DEF_TEMP_W,
    parameter int SLOPE  = DEF_SLOPE,
    parameter int OFFSET = DEF_OFFSET,
    parameter int TMAX   = DEF_TMAX
) (
    input  logic [CNT_W-1:0]  count_i,
    output logic [TEMP_W-1:0] temp_o
);
    int raw;

    always_comb begin
        raw = OFFSET - SLOPE * int'(count_i);
        if (raw < 0)         temp_o = '0;
        else if (raw > TMAX) temp_o = TEMP_W'(TMAX);
        else                 temp_o = TEMP_W'(raw);
    end

    // R7: the mapped value never leaves the calibrated span
    always_comb begin
        assert_in_span_R7: assert (int'(temp_o) <= TMAX);
    end
endmodule

// File: rtl/temp_readout.sv
`timescale 1ns/1ps
module temp_readout
    import temp_readout_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_clk,
    input  logic        gate,
    output logic        osc_en,
    output logic [9:0]  held_count,
    output logic        overflow,
    output logic [15:0] temp_q,
    output logic        result_valid
);
    localparam int CNT_W  = DEF_CNT_W;
    localparam int TEMP_W = DEF_TEMP_W;

    logic             osc_rst, run_s;
    logic [CNT_W-1:0] xfer_cnt;
    logic             xfer_ovf, xfer_tog;
    logic             tog_s, tog_d, tog_edge;
    logic [CNT_W-1:0] cap_cnt;
    logic             cap_ovf;
    logic [TEMP_W-1:0] cal_temp;
    seq_state_e       seq_q, seq_d;

    assign osc_en = gate;

    bit_sync2 u_rst_sync  (.clk(osc_clk), .d_i(rst),  .q_o(osc_rst));
    bit_sync2 u_gate_sync (.clk(osc_clk), .d_i(gate), .q_o(run_s));

    osc_window_counter #(.CNT_W(CNT_W)) u_counter (
        .osc_clk    (osc_clk),
        .osc_rst    (osc_rst),
        .run_i      (run_s),
        .hold_cnt_o (xfer_cnt),
        .hold_ovf_o (xfer_ovf),
        .hold_tog_o (xfer_tog)
    );

    bit_sync2 u_tog_sync (.clk(clk), .d_i(xfer_tog), .q_o(tog_s));

    always_ff @(posedge clk) begin
        if (rst) tog_d <= 1'b0;
        else     tog_d <= tog_s;
    end
    assign tog_edge = tog_s ^ tog_d;

    temp_calib #(.CNT_W(CNT_W), .TEMP_W(TEMP_W)) u_calib (
        .count_i (cap_cnt),
        .temp_o  (cal_temp)
    );

    always_comb begin
        unique case (seq_q)
            S_WAIT:    seq_d = tog_edge ? S_PUBLISH : S_WAIT;
            S_PUBLISH: seq_d = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= S_WAIT;
        else     seq_q <= seq_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_cnt      <= '0;
            cap_ovf      <= 1'b0;
            held_count   <= '0;
            overflow     <= 1'b0;
            temp_q       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            unique case (seq_q)
                S_WAIT: begin
                    if (tog_edge) begin
                        cap_cnt <= xfer_cnt;
                        cap_ovf <= xfer_ovf;
                    end
                end
                S_PUBLISH: begin
                    held_count   <= cap_cnt;
                    overflow     <= cap_ovf;
                    temp_q       <= cal_temp;
                    result_valid <= 1'b1;
                end
            endcase
        end
    end

    // R4: a closed gate never leaves the oscillator enabled
    assert_osc_off_R4: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !osc_en);

    // R5: published values do not move without a valid pulse
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!result_valid && !$past(rst)) |-> ($stable(held_count) && $stable(temp_q) && $stable(overflow)));

    // R8: the valid strobe is a single cycle
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);
endmodule

// File: tb/tb_temp_readout.sv
`timescale 1ns/1ps
module tb_temp_readout;
    localparam real CLK_PERIOD = 10.0;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_clk = 1'b0;
    logic        gate = 1'b0;
    logic        osc_en;
    logic [9:0]  held_count;
    logic        overflow;
    logic [15:0] temp_q;
    logic        result_valid;

    real osc_half = 1.0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int exp_cnt_q[$];
    int exp_ovf_q[$];
    int last_cnt = 0, last_ovf = 0, last_temp = 0;
    bit prev_valid = 1'b0;

    temp_readout dut (
        .clk(clk), .rst(rst), .osc_clk(osc_clk), .gate(gate),
        .osc_en(osc_en), .held_count(held_count), .overflow(overflow),
        .temp_q(temp_q), .result_valid(result_valid)
    );

    always #(CLK_PERIOD/2.0) clk = ~clk;
    always #(osc_half) osc_clk = ~osc_clk;

    function automatic int model_temp(input int c);
        int t;
        t = 101197 - 132 * c;
        if (t < 0) t = 0;
        if (t > 25600) t = 25600;
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            check(1'b0, "watchdog", cyc, WATCHDOG);
            finish_run();
        end
        if (rst) begin
            last_cnt = 0; last_ovf = 0; last_temp = 0;
            prev_valid = 1'b0;
        end else begin
            check(osc_en == gate, "R4 enable", int'(osc_en), int'(gate));
            if (result_valid) begin
                check(!prev_valid, "R8 pulse width", 1, 0);
                if (exp_cnt_q.size() == 0) begin
                    check(1'b0, "R8 unexpected pulse", 1, 0);
                end else begin
                    int ec, eo;
                    ec = exp_cnt_q.pop_front();
                    eo = exp_ovf_q.pop_front();
                    check(int'(held_count) == ec, "R1 R3 count", int'(held_count), ec);
                    check(int'(overflow) == eo, "R2 overflow", int'(overflow), eo);
                    check(int'(temp_q) == model_temp(ec), "R6 R7 temperature", int'(temp_q), model_temp(ec));
                end
                last_cnt = int'(held_count); last_ovf = int'(overflow); last_temp = int'(temp_q);
            end else begin
                check(int'(held_count) == last_cnt && int'(overflow) == last_ovf &&
                      int'(temp_q) == last_temp, "R5 hold", int'(temp_q), last_temp);
            end
            prev_valid = result_valid;
        end
    end

    task automatic window(input int n);
        @(negedge osc_clk);
        gate = 1'b1;
        repeat (n) @(negedge osc_clk);
        gate = 1'b0;
        exp_cnt_q.push_back(n > 1023 ? 1023 : n);
        exp_ovf_q.push_back(n > 1023 ? 1 : 0);
        repeat (60) @(negedge osc_clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_cnt_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_cnt_q.size() == 0, "R8 missing pulse", exp_cnt_q.size(), 0);
    endtask

    task automatic check_reset_state();
        check(held_count == 10'd0, "R9 count", int'(held_count), 0);
        check(overflow == 1'b0, "R9 overflow", int'(overflow), 0);
        check(temp_q == 16'd0, "R9 temperature", int'(temp_q), 0);
        check(result_valid == 1'b0, "R9 valid", int'(result_valid), 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (6) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 short windows, R3 consecutive unrelated lengths
        window(1);
        window(5);
        window(300);
        // R7 clamp edges
        window(572);
        window(573);
        window(766);
        window(767);
        // R2 saturation boundary
        window(1023);
        window(1024);
        window(1100);
        window(2);
        drain();

        // second oscillator period
        osc_half = 1.5;
        window(700);
        window(9);
        drain();

        // R9 reset between windows
        @(negedge clk);
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        window(640);
        drain();

        finish_run();
    end
endmodule